// File: doc/BRIEF.md
# Infrared Symbol Timing Capture Receiver

This block watches a demodulated remote-control input, either infrared or UHF. For each symbol it measures two durations in sampling ticks. The first is how long the carrier stayed present (the mark). The second is the whole symbol period, counted from the start of that mark to the start of the next one. Each pair is pushed into a small FIFO. A processor drains the FIFO through a simple register interface and computes the space time itself as period minus mark.

The measurement tick comes from a programmable divider of the system clock. A control bit can invert the raw input, which suits an active-low receiver pin. A programmable filter rejects short glitches before they can start or end a mark. When no new mark arrives within a programmable maximum period, the open symbol is closed with the saturated period value 0xFFFF, which tells software that the train has ended. Four maskable interrupt sources, with write-one-to-clear status bits, are combined into one interrupt line.

Top module: `ir_symbol_capture`

## Requirements
- R1: With receive enabled, each symbol is stored as a mark count and a period count in ticks. The mark count is the number of ticks the filtered input was high. The period count runs from the tick that starts the mark up to, but not including, the tick that starts the next mark.
- R2: If the period count in the space phase reaches the maximum-period register (index 6), the symbol is stored with period 0xFFFF. Interrupt status bit 1 (last symbol) is then set, and the next mark starts a fresh symbol.
- R3: The divider register (index 8) sets the tick to one per DIV clocks. A value of 0 or 1 gives one tick per clock.
- R4: Control register (index 5) bit 1 inverts the input before measurement, so a low level then counts as carrier.
- R5: An input change shorter than the noise register value (index 7) in ticks is ignored. It neither starts nor ends a mark, and symbol timing is unchanged.
- R6: The FIFO holds 8 entries in arrival order. Reading index 1 returns the head period without removing it. Reading index 0 returns the head mark and removes the entry.
- R7: A capture that arrives while the FIFO is full is dropped and sets status bit 2 (overrun). The push that fills the FIFO sets status bit 3 (full).
- R8: Interrupt status (index 3) bit 0 is set on every stored capture. Writing 1 to a bit of the clear register (index 4) clears that status bit. Output `irq` is high while any status bit is set together with its bit in the enable register (index 2).
- R9: With control bit 0 (receive enable) at 0, no capture is stored. The first mark after enable starts a new symbol.
- R10: The receive status register (index 9) reads 0xFF in bits 15:8 while the FIFO is not empty, and carries the overrun flag in bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_in | input | 1 | Demodulated receiver input (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops on index 0) |
| addr | input | 4 | Register index |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr |
| irq | output | 1 | Combined masked interrupt |

## Verification
A table of mark/space pairs, covering one-off short and long marks, short spaces and long spaces, checks that marks and periods come out independently and in order. The train ends in a long space, which shows that the 0xFFFF closing value differs from a normal period. Further runs use an inverted input, a divider of 4 and glitches shorter than the noise limit. These show that inversion swaps the carrier level, that the counts scale by the divider, and that glitches leave timing untouched. A run of ten symbols into the 8-entry FIFO separates dropped captures from stored ones, and a run with receive disabled must leave the FIFO empty.

// File: rtl/ir_symbol_capture.sv
module ir_symbol_capture #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_in,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [3:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         irq
);
  localparam logic [W-1:0] SAT = {W{1'b1}};
  localparam logic [W-1:0] TOP = SAT - 1'b1;

  logic [1:0]   ctrl;
  logic [3:0]   irq_en, irq_stat;
  logic [W-1:0] max_per, noise, div;
  logic [1:0]   sync;
  logic [W-1:0] div_cnt, gl_cnt, mk, pr;
  logic         lvl, active, in_mark;
  logic [W-1:0] mark_q [DEPTH];
  logic [W-1:0] per_q  [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt;

  wire en    = ctrl[0];
  wire s     = sync[1] ^ ctrl[1];
  wire tick  = ({1'b0, div_cnt} + 1'b1) >= {1'b0, div};
  wire full  = cnt == DEPTH[AW:0];
  wire empty = cnt == '0;
  wire tmo   = ({1'b0, pr} + 1'b1) >= {1'b0, max_per};
  wire push_req = en && tick && active && !in_mark && (lvl || tmo);
  wire [W-1:0] push_per = lvl ? pr : SAT;
  wire push  = push_req && !full;
  wire pop   = rd_en && addr == 4'd0 && !empty;
  wire wr_clr = wr_en && addr == 4'd4;
  wire [3:0] set = {push && cnt == DEPTH[AW:0] - 1'b1, push_req && full,
                    push && !lvl, push};

  assign irq = |(irq_stat & irq_en);

  always_comb begin
    case (addr)
      4'd0:    rdata = mark_q[rptr];
      4'd1:    rdata = per_q[rptr];
      4'd2:    rdata = W'(irq_en);
      4'd3:    rdata = W'(irq_stat);
      4'd5:    rdata = W'(ctrl);
      4'd6:    rdata = max_per;
      4'd7:    rdata = noise;
      4'd8:    rdata = div;
      4'd9:    rdata = {{8{!empty}}, 5'd0, irq_stat[2], 2'd0};
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; irq_en <= '0; irq_stat <= '0;
      max_per <= TOP; noise <= '0; div <= W'(1);
      sync <= '0; div_cnt <= '0; gl_cnt <= '0; lvl <= 1'b0;
      active <= 1'b0; in_mark <= 1'b0; mk <= '0; pr <= '0;
      wptr <= '0; rptr <= '0; cnt <= '0;
    end else begin
      sync <= {sync[0], rx_in};
      if (wr_en)
        case (addr)
          4'd2: irq_en  <= wdata[3:0];
          4'd5: ctrl    <= wdata[1:0];
          4'd6: max_per <= wdata;
          4'd7: noise   <= wdata;
          4'd8: div     <= wdata;
          default: ;
        endcase
      irq_stat <= (irq_stat & ~(wr_clr ? wdata[3:0] : 4'd0)) | set;
      div_cnt  <= tick ? '0 : div_cnt + 1'b1;
      if (tick) begin
        if (s == lvl) gl_cnt <= '0;
        else if (({1'b0, gl_cnt} + 1'b1) >= {1'b0, noise}) begin
          lvl <= s; gl_cnt <= '0;
        end else gl_cnt <= gl_cnt + 1'b1;
      end
      if (!en) begin
        active <= 1'b0; in_mark <= 1'b0; mk <= '0; pr <= '0;
      end else if (tick) begin
        if (!active) begin
          if (lvl) begin active <= 1'b1; in_mark <= 1'b1; mk <= W'(1); pr <= W'(1); end
        end else if (in_mark) begin
          if (pr != TOP) pr <= pr + 1'b1;
          if (!lvl) in_mark <= 1'b0;
          else if (mk != TOP) mk <= mk + 1'b1;
        end else if (lvl) begin
          in_mark <= 1'b1; mk <= W'(1); pr <= W'(1);
        end else if (tmo) begin
          active <= 1'b0;
        end else if (pr != TOP) pr <= pr + 1'b1;
      end
      if (push) begin
        mark_q[wptr] <= mk; per_q[wptr] <= push_per; wptr <= wptr + 1'b1;
      end
      if (pop) rptr <= rptr + 1'b1;
      cnt <= cnt + AW'(push) - AW'(pop);
    end
  end

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= DEPTH[AW:0]);
  assert_fill_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> cnt == $past(cnt) + 1'b1);
  assert_drop_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop) |=> (cnt == DEPTH[AW:0] && irq_stat[2]));
  assert_last_tagged_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && push_per == SAT) |=> (irq_stat[1] && !active));
  assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !push_req);
  assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> cnt == $past(cnt) - 1'b1 + AW'($past(push)));
endmodule

// File: tb/test_ir_symbol_capture.sv
module test_ir_symbol_capture;
  logic clk = 0, rst_n = 0, rx_in = 0, wr_en = 0, rd_en = 0;
  logic [3:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  ir_symbol_capture i_ir_symbol_capture (.*);
  always #5 clk = ~clk;

  localparam int NV = 6;
  localparam int VEC [NV][2] = '{'{5,7}, '{12,4}, '{30,20}, '{2,2}, '{60,100}, '{9,300}};

  task automatic chk(string r, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask
  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask
  task automatic pulse(int m, int s, logic inv);
    @(negedge clk); rx_in = ~inv;
    repeat (m) @(negedge clk);
    rx_in = inv;
    repeat (s - 1) @(negedge clk);
  endtask
  task automatic expect_entry(string r, int m, int p);
    logic [15:0] d;
    rd(4'd1, d); chk(r, d, 16'(p));
    rd(4'd0, d); chk(r, d, 16'(m));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk); rst_n = 1;
    // reset state
    rd(4'd3, d); chk("R8 reset status", d, 0);
    rd(4'd9, d); chk("R10 reset rx status", d, 0);
    chk("R8 reset irq", 16'(irq), 0);

    // R1 R2: table of symbols ending in a timeout
    wr(4'd6, 16'd200); wr(4'd2, 16'h3); wr(4'd5, 16'h1);
    for (int i = 0; i < NV; i++) pulse(VEC[i][0], VEC[i][1], 0);
    repeat (10) @(negedge clk);
    chk("R8 irq with data", 16'(irq), 1);
    rd(4'd3, d); chk("R2 last-symbol bit", d & 16'h2, 16'h2);
    rd(4'd9, d); chk("R10 not-empty field", d, 16'hFF00);
    for (int i = 0; i < NV; i++)
      expect_entry("R1 table entry", VEC[i][0],
                   (i == NV - 1) ? 16'hFFFF : VEC[i][0] + VEC[i][1]);
    rd(4'd9, d); chk("R6 drained", d, 0);
    wr(4'd4, 16'hF);
    rd(4'd3, d); chk("R8 W1C clears", d, 0);
    chk("R8 irq low", 16'(irq), 0);

    // R7 overrun
    for (int i = 0; i < 10; i++) pulse(4, 4, 0);
    repeat (300) @(negedge clk);
    rd(4'd3, d); chk("R7 overrun and full bits", d & 16'hC, 16'hC);
    rd(4'd9, d); chk("R10 overflow flag", d, 16'hFF04);
    for (int i = 0; i < 8; i++) expect_entry("R7 kept entry", 4, 8);
    rd(4'd9, d); chk("R7 only 8 stored", d & 16'hFF00, 0);
    wr(4'd4, 16'h4);
    rd(4'd3, d); chk("R7 overrun cleared", d & 16'h4, 0);
    wr(4'd4, 16'hF);

    // R9 disabled
    wr(4'd5, 16'h0);
    pulse(10, 10, 0); pulse(10, 300, 0);
    rd(4'd9, d); chk("R9 nothing stored", d, 0);
    rd(4'd3, d); chk("R9 no status", d, 0);

    // R4 inverted input
    @(negedge clk); rx_in = 1;
    wr(4'd5, 16'h3);
    repeat (5) @(negedge clk);
    pulse(15, 25, 1); pulse(10, 300, 1);
    expect_entry("R4 inverted", 15, 40);
    expect_entry("R4 inverted end", 10, 16'hFFFF);
    @(negedge clk); rx_in = 0;
    wr(4'd5, 16'h0); wr(4'd5, 16'h1);

    // R3 divider of 4
    wr(4'd8, 16'd4);
    pulse(40, 40, 0); pulse(20, 1200, 0);
    expect_entry("R3 divided", 10, 20);
    expect_entry("R3 divided end", 5, 16'hFFFF);
    wr(4'd8, 16'd1);

    // R5 noise filter
    wr(4'd7, 16'd5);
    pulse(3, 20, 0);
    rd(4'd9, d); chk("R5 glitch no start", d, 0);
    @(negedge clk); rx_in = 1; repeat (20) @(negedge clk);
    rx_in = 0; repeat (10) @(negedge clk);
    rx_in = 1; repeat (3) @(negedge clk);
    rx_in = 0; repeat (16) @(negedge clk);
    pulse(20, 300, 0);
    expect_entry("R5 glitch in space", 20, 50);
    expect_entry("R5 end", 20, 16'hFFFF);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule